// File: doc/BRIEF.md
# Programmable Color Space Converter

This block sits between a pixel fetch path and a display output and converts one 24-bit pixel per clock between the RGB and YCbCr color domains. It can also pass pixels through untouched. A 3x3 matrix of signed fixed-point weights and three signed offsets define the conversion. The weights and offsets are packed into six 32-bit words. A separate control word selects the operating mode. Software loads all of these through a write-only register port.

The conversion runs as a three-stage pipeline that accepts a new pixel every cycle:

- Stage 1 captures the pixel and the current mode. In YCbCr-to-RGB mode it also adds the offsets to the input components.
- Stage 2 forms the three weighted sums.
- Stage 3 adds the offsets (in RGB-to-YCbCr mode only), rounds, clamps the result to 8 bits and registers it.

The mode is a three-state machine with these states:

- **BYPASS**: entered on reset and on control code 0.
- **YC2RGB**: entered on control code 1.
- **RGB2YC**: entered on control code 2.

A control write with code 1 or 2 takes one of the two select transitions. A control write with code 0 takes the back-to-bypass transition. Control code 3, and any cycle without a control write, take the self-loop and leave the state unchanged. Each pixel carries the state it saw on entry through the whole pipeline.

Top module: `csc_top`

## Requirements
- R1: After reset, the mode is BYPASS, all weights and offsets are zero, `out_valid` is 0 and `out_pix` is 0. Selecting a conversion mode with no weights loaded therefore yields 0 on every component.
- R2: Register map, by `cfg_addr`:
  - Addresses 0 to 5 hold the packed words. Each word carries its lower field at bits [10:0] and its upper field at bits [26:16]. Offset fields are 9 bits wide, at [8:0] or [24:16].
  - Word contents as {upper, lower}: 0 = {A2,A1}, 1 = {B1,A3}, 2 = {B3,B2}, 3 = {C2,C1}, 4 = {D1,C3}, 5 = {D3,D2}.
  - Address 6 is the control word, with the mode code in bits [1:0].
  - A write to address 7 has no effect.
- R3: A control write with code 3 leaves the mode unchanged.
- R4: Pixels are packed as {c0, c1, c2}, with c0 in bits [23:16], c1 in [15:8] and c2 in [7:0]. That is {R,G,B} in the RGB domain and {Y,Cb,Cr} in the YCbCr domain.
- R5: In BYPASS (code 0), `out_pix` equals the input pixel.
- R6: In YC2RGB (code 1), output component j equals W_j0·(c0+D1) + W_j1·(c1+D2) + W_j2·(c2+D3). Row 0 uses A1..A3, row 1 uses B1..B3 and row 2 uses C1..C3. Weights are 11-bit two's-complement values with 8 fraction bits; offsets are 9-bit two's-complement integers.
- R7: In RGB2YC (code 2), output component j equals W_j0·c0 + W_j1·c1 + W_j2·c2 + D(j+1). The offset is added after the weighted sum.
- R8: Each converted sum is rounded by adding 128 (in units of 1/256) and then floor-shifted right by 8. Results below 0 become 0 and results above 255 become 255.
- R9: `out_valid` repeats `in_valid` exactly three cycles later, with one register per stage. While `out_valid` is low, `out_pix` holds its last value.
- R10: A pixel uses the mode in force when it is captured. A control write on the same clock edge as a pixel affects only the pixels that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel {c0,c1,c2} |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Converted pixel {c0,c1,c2} |

## Verification
A pixel driven during cycle t is captured at the next rising edge. Its result, and its copy of `in_valid`, appear on the outputs two edges later, so they are visible during cycle t+3.

The bench keeps a two-entry delay line of expected results and reads the outputs at each falling edge:

- Every cycle it compares `out_valid` with the valid flag from two steps back.
- When that flag is set, it also compares `out_pix` with the pixel expected from two steps back.

Register writes complete at the edge that samples them. The bench therefore computes a pixel's expected value with the mode that was in force before any write issued in the same cycle. It changes weights only after the pipeline has drained through idle cycles, because weights are read live by stages 2 and 3.

// File: rtl/csc_pkg.sv
package csc_pkg;
    parameter int COMP_W = 8;
    parameter int NCH    = 3;
    parameter int COEF_W = 11;
    parameter int OFS_W  = 9;
    parameter int FRAC_W = 8;
    parameter int CFG_AW = 3;
    parameter int CFG_DW = 32;

    localparam int PIX_W     = COMP_W * NCH;
    localparam int X_W       = COMP_W + 2;
    localparam int ACC_W     = COEF_W + X_W + 2;
    localparam int NCOEF     = NCH * NCH;
    localparam int NSLOT     = NCOEF + NCH;
    localparam int NWORD     = NSLOT / 2;
    localparam int CTRL_ADDR = NWORD;
    localparam int HI_LSB    = CFG_DW / 2;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_YC2RGB = 2'd1,
        MODE_RGB2YC = 2'd2
    } csc_mode_e;
endpackage

// File: rtl/csc_cfg.sv
module csc_cfg
    import csc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output csc_mode_e                mode_o,
    output logic signed [COEF_W-1:0] k_o [NCOEF],
    output logic signed [OFS_W-1:0]  d_o [NCH]
);
    logic [CFG_DW-1:0] word_q [NWORD];
    csc_mode_e         mode_q, mode_d;
    logic              ctrl_wr;

    assign ctrl_wr = cfg_we && (cfg_addr == CFG_AW'(CTRL_ADDR));

    // packed weight/offset words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < NWORD; i++)
                if (cfg_we && cfg_addr == CFG_AW'(i)) word_q[i] <= cfg_wdata;
        end
    end

    // slot s lives in word s/2, odd slots in the upper half-word
    for (genvar n = 0; n < NCOEF; n++) begin : g_k
        assign k_o[n] = word_q[n/2][(n%2)*HI_LSB +: COEF_W];
    end
    for (genvar j = 0; j < NCH; j++) begin : g_d
        localparam int S = NCOEF + j;
        assign d_o[j] = word_q[S/2][(S%2)*HI_LSB +: OFS_W];
    end

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_BYPASS;
        else        mode_q <= mode_d;
    end

    // mode transitions
    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr) begin
            unique case (cfg_wdata[1:0])
                2'd0:    mode_d = MODE_BYPASS;
                2'd1:    mode_d = MODE_YC2RGB;
                2'd2:    mode_d = MODE_RGB2YC;
                default: mode_d = mode_q;
            endcase
        end
    end

    assign mode_o = mode_q;

    assert_bad_code_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_wdata[1:0] == 2'd3) |=> (mode_q == $past(mode_q)));

    assert_upper_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == '0) |=> (k_o[1] == $past(cfg_wdata[HI_LSB +: COEF_W])));
endmodule

// File: rtl/csc_lane.sv
module csc_lane
    import csc_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v1_i,
    input  logic                     v2_i,
    input  csc_mode_e                mode1_i,
    input  logic [COMP_W-1:0]        raw1_i,
    input  logic signed [X_W-1:0]    x_i [NCH],
    input  logic signed [COEF_W-1:0] k_i [NCOEF],
    input  logic signed [OFS_W-1:0]  ofs_i,
    output logic [COMP_W-1:0]        comp_o
);
    localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << COMP_W) - 1);

    logic signed [ACC_W-1:0] mac_d, acc2, tot, shifted;
    csc_mode_e               mode2;
    logic [COMP_W-1:0]       raw2, sat, res;

    // stage 2: weighted sum of this row
    always_comb begin
        mac_d = '0;
        for (int i = 0; i < NCH; i++)
            mac_d = mac_d + ACC_W'(k_i[ROW*NCH + i]) * ACC_W'(x_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc2  <= '0;
            mode2 <= MODE_BYPASS;
            raw2  <= '0;
        end else if (v1_i) begin
            acc2  <= mac_d;
            mode2 <= mode1_i;
            raw2  <= raw1_i;
        end
    end

    // stage 3: post offset, round, clamp
    always_comb begin
        unique case (mode2)
            MODE_RGB2YC: tot = acc2 + (ACC_W'(ofs_i) <<< FRAC_W) + RND;
            default:     tot = acc2 + RND;
        endcase
        shifted = tot >>> FRAC_W;
        if (shifted[ACC_W-1])     sat = '0;
        else if (shifted > SAT_HI) sat = '1;
        else                       sat = shifted[COMP_W-1:0];
        unique case (mode2)
            MODE_BYPASS: res = raw2;
            default:     res = sat;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    comp_o <= '0;
        else if (v2_i) comp_o <= res;
    end

    assert_bypass_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_i && mode2 == MODE_BYPASS) |=> (comp_o == $past(raw2)));

    assert_clamp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_i && mode2 != MODE_BYPASS && tot[ACC_W-1]) |=> (comp_o == '0));
endmodule

// File: rtl/csc_top.sv
module csc_top
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    csc_mode_e               cur_mode, mode1;
    logic signed [COEF_W-1:0] kq [NCOEF];
    logic signed [OFS_W-1:0]  dq [NCH];
    logic signed [X_W-1:0]    x1 [NCH];
    logic [COMP_W-1:0]        raw1 [NCH];
    logic                     v1, v2, pre_en;

    csc_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_o    (cur_mode),
        .k_o       (kq),
        .d_o       (dq)
    );

    // offsets go in front of the matrix only when decoding YCbCr
    always_comb begin
        unique case (cur_mode)
            MODE_YC2RGB: pre_en = 1'b1;
            default:     pre_en = 1'b0;
        endcase
    end

    // stage 1: capture pixel and mode, pre-add
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
            mode1     <= MODE_BYPASS;
            for (int i = 0; i < NCH; i++) begin
                x1[i]   <= '0;
                raw1[i] <= '0;
            end
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
            if (in_valid) begin
                mode1 <= cur_mode;
                for (int i = 0; i < NCH; i++) begin
                    raw1[i] <= in_pix[(NCH-1-i)*COMP_W +: COMP_W];
                    x1[i]   <= $signed(X_W'(in_pix[(NCH-1-i)*COMP_W +: COMP_W]))
                             + (pre_en ? X_W'(dq[i]) : '0);
                end
            end
        end
    end

    for (genvar j = 0; j < NCH; j++) begin : g_lane
        csc_lane #(.ROW(j)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .v1_i    (v1),
            .v2_i    (v2),
            .mode1_i (mode1),
            .raw1_i  (raw1[j]),
            .x_i     (x1),
            .k_i     (kq),
            .ofs_i   (dq[j]),
            .comp_o  (out_pix[(NCH-1-j)*COMP_W +: COMP_W])
        );
    end

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |=> out_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |=> !out_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |=> $stable(out_pix));

    assert_mode_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (mode1 == $past(cur_mode)));
endmodule

// File: tb/tb_csc_top.sv
module tb_csc_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        in_valid;
    logic [23:0] in_pix;
    logic        out_valid;
    logic [23:0] out_pix;

    always #10 clk = ~clk;

    csc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int rk [9];
    int rd [3];
    int ck [9];
    int co [3];
    int bmode = 0;
    string tag_ovr = "";
    bit p1v = 0, p2v = 0;
    logic [23:0] p1d = '0, p2d = '0;
    string p1t = "", p2t = "";
    int seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic logic [23:0] model(input logic [23:0] p, output bit clip);
        int c [3];
        int acc, r;
        logic [23:0] o;
        clip = 0;
        o = '0;
        for (int i = 0; i < 3; i++) c[i] = int'(p[(2-i)*8 +: 8]);
        for (int j = 0; j < 3; j++) begin
            acc = 0;
            for (int i = 0; i < 3; i++)
                acc += sx(rk[3*j+i], 11) * (c[i] + ((bmode == 1) ? sx(rd[i], 9) : 0));
            if (bmode == 2) acc += sx(rd[j], 9) * 256;
            acc += 128;
            r = acc >>> 8;
            if (r < 0) begin r = 0; clip = 1; end
            else if (r > 255) begin r = 255; clip = 1; end
            o[(2-j)*8 +: 8] = 8'(r);
        end
        if (bmode == 0) begin
            o = p;
            clip = 0;
        end
        return o;
    endfunction

    task automatic apply_write(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd0: begin rk[0] = int'(d[10:0]); rk[1] = int'(d[26:16]); end
            3'd1: begin rk[2] = int'(d[10:0]); rk[3] = int'(d[26:16]); end
            3'd2: begin rk[4] = int'(d[10:0]); rk[5] = int'(d[26:16]); end
            3'd3: begin rk[6] = int'(d[10:0]); rk[7] = int'(d[26:16]); end
            3'd4: begin rk[8] = int'(d[10:0]); rd[0] = int'(d[24:16]); end
            3'd5: begin rd[1] = int'(d[8:0]);  rd[2] = int'(d[24:16]); end
            3'd6: if (d[1:0] != 2'd3) bmode = int'(d[1:0]);
            default: ;
        endcase
    endtask

    // one clock: drive, then check the output due from two steps back
    task automatic step(input bit v, input logic [23:0] pix, input bit w,
                        input logic [2:0] a, input logic [31:0] d);
        logic [23:0] e;
        string t;
        bit clip;
        in_valid  = v;
        in_pix    = pix;
        cfg_we    = w;
        cfg_addr  = a;
        cfg_wdata = d;
        e = model(pix, clip);
        t = (bmode == 0) ? "R5" : (bmode == 1) ? "R6" : "R7";
        if (clip) t = "R8";
        if (tag_ovr != "") t = tag_ovr;
        if (w) apply_write(a, d);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == p2v, "R9 valid", 24'(out_valid), 24'(p2v));
        if (p2v) chk(out_pix == p2d, p2t, out_pix, p2d);
        p2v = p1v; p2d = p1d; p2t = p1t;
        p1v = v;   p1d = e;   p1t = t;
        cfg_we   = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 3'd0, '0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(0, '0, 1, a, d);
    endtask

    task automatic load();
        idle(3);
        wr(3'd0, 32'(ck[1] << 16 | ck[0]));
        wr(3'd1, 32'(ck[3] << 16 | ck[2]));
        wr(3'd2, 32'(ck[5] << 16 | ck[4]));
        wr(3'd3, 32'(ck[7] << 16 | ck[6]));
        wr(3'd4, 32'(co[0] << 16 | ck[8]));
        wr(3'd5, 32'(co[2] << 16 | co[1]));
    endtask

    task automatic grid(input bit bubbles);
        int n = 0;
        for (int a = 0; a < 256; a += 17)
            for (int b = 0; b < 256; b += 17)
                for (int c = 0; c < 256; c += 17) begin
                    step(1, {8'(a), 8'(b), 8'(c)}, 0, 3'd0, '0);
                    n++;
                    if (bubbles && (n % 5 == 0)) step(0, '0, 0, 3'd0, '0);
                end
    endtask

    function automatic logic [23:0] rnd24();
        seed = seed * 1103515245 + 12345;
        return 24'(seed >>> 4);
    endfunction

    initial begin
        #3_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; in_valid = 0; in_pix = '0;
        for (int i = 0; i < 9; i++) rk[i] = 0;
        for (int i = 0; i < 3; i++) rd[i] = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", 24'(out_valid), 24'd0);
        chk(out_pix == '0, "R1 reset pixel", out_pix, '0);
        rst_n = 1'b1;

        // R1: bypass default, then zero weights
        tag_ovr = "R1";
        step(1, 24'h12_34_56, 0, 3'd0, '0);
        step(1, 24'hFF_00_80, 0, 3'd0, '0);
        wr(3'd6, 32'd1);
        step(1, 24'h80_80_80, 0, 3'd0, '0);
        step(1, 24'hFF_FF_FF, 0, 3'd0, '0);
        tag_ovr = "";

        // R6: full-range 601-style decode
        ck = '{32'h100, 32'h000, 32'h167, 32'h100, 32'h7a8, 32'h749, 32'h100, 32'h1c6, 32'h000};
        co = '{32'h000, 32'h180, 32'h180};
        load();
        grid(0);

        // R6 with limited-range weights and bubbles (R9)
        ck = '{32'h12a, 32'h000, 32'h1cb, 32'h12a, 32'h7c9, 32'h778, 32'h12a, 32'h21d, 32'h000};
        co = '{32'h1f0, 32'h180, 32'h180};
        load();
        grid(1);

        // R3: code 3 ignored; R2: address 7 ignored
        tag_ovr = "R3";
        wr(3'd6, 32'd3);
        for (int i = 0; i < 8; i++) step(1, rnd24(), 0, 3'd0, '0);
        tag_ovr = "R2";
        wr(3'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) step(1, rnd24(), 0, 3'd0, '0);
        tag_ovr = "";

        // R7: encode with post offsets
        ck = '{32'h041, 32'h081, 32'h019, 32'h7db, 32'h7b6, 32'h070, 32'h070, 32'h7a2, 32'h7ee};
        co = '{32'h010, 32'h080, 32'h080};
        load();
        wr(3'd6, 32'd2);
        grid(0);

        // R10: mode writes in the same cycle as pixels
        tag_ovr = "R10";
        for (int i = 0; i < 24; i++)
            step(1, rnd24(), 1, 3'd6, 32'(i % 3));
        tag_ovr = "";

        // R4 R5: bypass sweep
        wr(3'd6, 32'd0);
        tag_ovr = "R4 R5";
        grid(0);
        tag_ovr = "";

        // R8: extreme weights force clamping both ways
        ck = '{32'h3ff, 32'h3ff, 32'h3ff, 32'h400, 32'h400, 32'h400, 32'h100, 32'h7c0, 32'h040};
        co = '{32'h0ff, 32'h100, 32'h0a5};
        load();
        wr(3'd6, 32'd1);
        for (int i = 0; i < 600; i++) step(1, rnd24(), 0, 3'd0, '0);
        wr(3'd6, 32'd2);
        for (int i = 0; i < 600; i++) step(1, rnd24(), 0, 3'd0, '0);
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule